// File: doc/BRIEF.md
# Cache-Line Flit Packetizer

This block sits on the send side of a network interface. It takes one coherence message per handshake and turns it into a stream of fixed-width flits for the router. Each message has a command, a destination, a flag that says whether a cache line comes with it, and the 64-byte line. A message without a line leaves as a single flit. A message with a line leaves as a head flit followed by four data flits. The data flits carry the line in 16-byte pieces, lowest address first.

Every flit carries a two-bit kind field and an eight-bit sequence number. The far end uses the sequence number to match replies to outstanding requests and to spot lost or reordered packets. All flits of one packet carry the same number. The number steps by one per packet and wraps from 255 to 0.

A controller with three states drives the output. `ST_IDLE` accepts a message: on `in_valid` it goes to `ST_HEAD` and loads the message. `ST_HEAD` offers the head flit. When that flit is handed off, the controller goes to `ST_DATA` if a line is present and back to `ST_IDLE` if not. `ST_DATA` offers one data flit per handoff. After the last data flit is handed off it returns to `ST_IDLE`.

Top module: `flit_packetizer`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and the first packet sent carries sequence number 0.
- R2: A message with `in_has_line`=0 produces exactly one flit of kind 2'b11 (head-and-tail). The packet ends there and `in_ready` returns to 1 on the cycle after the handoff.
- R3: A message with `in_has_line`=1 produces five flits. Their kinds, in order, are 2'b00 (head), three times 2'b01 (body), then 2'b10 (tail).
- R4: Data flit k (k = 0..3, counted after the head) carries bits [128k+127:128k] of the accepted line, which is line bytes 16k to 16k+15.
- R5: A head flit (kind 2'b00 or 2'b11) carries the command in payload bits [7:0] and the destination in bits [13:8]. All other payload bits are 0.
- R6: Every flit of a packet carries the same `out_seq`. Each new packet's number is the previous packet's number plus one, modulo 256.
- R7: `in_ready` stays 0 from the cycle after a message is accepted until the handoff of that packet's last flit. Input values presented during that time have no effect on the packet in flight.
- R8: While `out_valid`=1 and `out_ready`=0, the outputs `out_valid`, `out_kind`, `out_seq` and `out_payload` hold their values into the next cycle.
- R9: A flit advances only when it is handed off (`out_valid` and `out_ready` both 1 at a clock edge). No flit is dropped or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A message is offered |
| in_ready | output | 1 | The block can accept a message |
| in_cmd | input | 8 | Coherence command |
| in_dest | input | 6 | Destination node |
| in_has_line | input | 1 | The message carries a cache line |
| in_line | input | 512 | Cache line, byte 0 in bits [7:0] |
| out_valid | output | 1 | A flit is offered |
| out_ready | input | 1 | The network accepts the flit |
| out_kind | output | 2 | Flit kind: 00 head, 01 body, 10 tail, 11 head-and-tail |
| out_seq | output | 8 | Packet sequence number |
| out_payload | output | 128 | Flit payload |

## Verification
The properties assume that `out_ready` may take any pattern, including long stalls, and that inputs carry known values once reset is released. They do not assume that `in_valid` is held or that the message fields stay steady after acceptance.

The stimulus stays inside those assumptions and also tests them hard. It changes `out_ready` from a pseudo-random sequence in some phases and holds it high in others. Right after each acceptance it inverts every message field, including the line-present flag. It runs enough packets for the sequence number to wrap.

// File: rtl/flitpk_pkg.sv
package flitpk_pkg;

    typedef enum logic [1:0] {
        FK_HEAD = 2'b00,
        FK_BODY = 2'b01,
        FK_TAIL = 2'b10,
        FK_SOLO = 2'b11
    } flit_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_HEAD = 2'b01,
        ST_DATA = 2'b10
    } pk_state_t;

endpackage

// File: rtl/pkt_seq_gen.sv
module pkt_seq_gen #(
    parameter int SEQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [SEQ_W-1:0] seq_o
);

    logic [SEQ_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (advance) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign seq_o = count_q;

endmodule

// File: rtl/pkt_chunk_sel.sv
module pkt_chunk_sel #(
    parameter int LINE_W     = 512,
    parameter int FLIT_W     = 128,
    parameter int DATA_FLITS = 4,
    parameter int IDX_W      = 2
) (
    input  logic [LINE_W-1:0] line_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [FLIT_W-1:0] chunk_o
);

    logic [FLIT_W-1:0] slices [DATA_FLITS];

    for (genvar g = 0; g < DATA_FLITS; g++) begin : g_slice
        assign slices[g] = line_i[g*FLIT_W +: FLIT_W];
    end

    always_comb begin
        chunk_o = slices[0];
        for (int k = 0; k < DATA_FLITS; k++) begin
            if (idx_i == IDX_W'(k)) begin
                chunk_o = slices[k];
            end
        end
    end

endmodule

// File: rtl/pkt_ctrl.sv
module pkt_ctrl
    import flitpk_pkg::*;
#(
    parameter int DATA_FLITS = 4,
    parameter int IDX_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             line_q,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             take_msg,
    output logic             out_valid,
    output flit_kind_t       kind,
    output logic [IDX_W-1:0] chunk_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_FLITS - 1);

    pk_state_t        state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    state_d = ST_HEAD;
                end
            end
            ST_HEAD: begin
                if (out_ready) begin
                    if (line_q) begin
                        state_d = ST_DATA;
                        idx_d   = '0;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_DATA: begin
                if (out_ready) begin
                    if (idx_q == LAST_IDX) begin
                        state_d = ST_IDLE;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        kind      = FK_HEAD;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
            end
            ST_HEAD: begin
                out_valid = 1'b1;
                kind      = line_q ? FK_HEAD : FK_SOLO;
            end
            ST_DATA: begin
                out_valid = 1'b1;
                kind      = (idx_q == LAST_IDX) ? FK_TAIL : FK_BODY;
            end
            default: begin
                in_ready = 1'b0;
            end
        endcase
        take_msg  = in_ready && in_valid;
        chunk_idx = idx_q;
    end

endmodule

// File: rtl/flit_packetizer.sv
module flit_packetizer
    import flitpk_pkg::*;
#(
    parameter int FLIT_BYTES = 16,
    parameter int LINE_BYTES = 64,
    parameter int CMD_W      = 8,
    parameter int DEST_W     = 6,
    parameter int SEQ_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [CMD_W-1:0]        in_cmd,
    input  logic [DEST_W-1:0]       in_dest,
    input  logic                    in_has_line,
    input  logic [LINE_BYTES*8-1:0] in_line,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [1:0]              out_kind,
    output logic [SEQ_W-1:0]        out_seq,
    output logic [FLIT_BYTES*8-1:0] out_payload
);

    localparam int FLIT_W     = FLIT_BYTES * 8;
    localparam int LINE_W     = LINE_BYTES * 8;
    localparam int DATA_FLITS = LINE_BYTES / FLIT_BYTES;
    localparam int IDX_W      = (DATA_FLITS > 1) ? $clog2(DATA_FLITS) : 1;

    logic              take_msg;
    logic [SEQ_W-1:0]  next_seq;
    flit_kind_t        kind;
    logic [IDX_W-1:0]  chunk_idx;
    logic [FLIT_W-1:0] chunk;

    logic [CMD_W-1:0]  cmd_q;
    logic [DEST_W-1:0] dest_q;
    logic              line_q;
    logic [LINE_W-1:0] data_q;
    logic [SEQ_W-1:0]  seq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            dest_q <= '0;
            line_q <= 1'b0;
            data_q <= '0;
            seq_q  <= '0;
        end else if (take_msg) begin
            cmd_q  <= in_cmd;
            dest_q <= in_dest;
            line_q <= in_has_line;
            data_q <= in_line;
            seq_q  <= next_seq;
        end
    end

    pkt_ctrl #(
        .DATA_FLITS(DATA_FLITS),
        .IDX_W     (IDX_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .line_q   (line_q),
        .out_ready(out_ready),
        .in_ready (in_ready),
        .take_msg (take_msg),
        .out_valid(out_valid),
        .kind     (kind),
        .chunk_idx(chunk_idx)
    );

    pkt_seq_gen #(
        .SEQ_W(SEQ_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(take_msg),
        .seq_o  (next_seq)
    );

    pkt_chunk_sel #(
        .LINE_W    (LINE_W),
        .FLIT_W    (FLIT_W),
        .DATA_FLITS(DATA_FLITS),
        .IDX_W     (IDX_W)
    ) u_chunk (
        .line_i (data_q),
        .idx_i  (chunk_idx),
        .chunk_o(chunk)
    );

    always_comb begin
        out_kind = kind;
        out_seq  = seq_q;
        if (kind == FK_HEAD || kind == FK_SOLO) begin
            out_payload = FLIT_W'({dest_q, cmd_q});
        end else begin
            out_payload = chunk;
        end
    end

endmodule

// File: rtl/flit_packetizer_chk.sv
module flit_packetizer_chk
    import flitpk_pkg::*;
#(
    parameter int SEQ_W      = 8,
    parameter int FLIT_W     = 128,
    parameter int DATA_FLITS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [1:0]        out_kind,
    input logic [SEQ_W-1:0]  out_seq,
    input logic [FLIT_W-1:0] out_payload
);

    logic             hs;
    logic             head_like;
    logic [SEQ_W-1:0] last_seq;
    logic             seen;
    logic [7:0]       body_cnt;

    assign hs        = out_valid && out_ready;
    assign head_like = (out_kind == FK_HEAD) || (out_kind == FK_SOLO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_seq <= '0;
            seen     <= 1'b0;
            body_cnt <= '0;
        end else if (hs) begin
            if (head_like) begin
                last_seq <= out_seq;
                seen     <= 1'b1;
                body_cnt <= '0;
            end else if (out_kind == FK_BODY) begin
                body_cnt <= body_cnt + 1'b1;
            end
        end
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_kind)
            && $stable(out_seq) && $stable(out_payload));

    assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_seq_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hs && head_like && seen |-> out_seq == last_seq + 1'b1);

    assert_seq_same_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !head_like |-> seen && out_seq == last_seq);

    assert_after_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hs && out_kind == FK_HEAD |=> out_valid && (out_kind == FK_BODY || out_kind == FK_TAIL));

    assert_tail_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hs && out_kind == FK_TAIL |-> body_cnt == 8'(DATA_FLITS - 1));

    assert_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hs && (out_kind == FK_SOLO || out_kind == FK_TAIL) |=> in_ready && !out_valid);

endmodule

bind flit_packetizer flit_packetizer_chk #(
    .SEQ_W     (SEQ_W),
    .FLIT_W    (FLIT_W),
    .DATA_FLITS(DATA_FLITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_kind   (out_kind),
    .out_seq    (out_seq),
    .out_payload(out_payload)
);

// File: tb/flit_packetizer_test.sv
module flit_packetizer_test;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]   kind;
        logic [7:0]   seq;
        logic [127:0] pay;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [7:0]   in_cmd = '0;
    logic [5:0]   in_dest = '0;
    logic         in_has_line = 1'b0;
    logic [511:0] in_line = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [1:0]   out_kind;
    logic [7:0]   out_seq;
    logic [127:0] out_payload;

    int     checks = 0;
    int     errors = 0;
    exp_t   expq[$];
    logic [7:0] exp_seq = '0;
    logic   stall_mode = 1'b0;
    logic   mon_on = 1'b0;
    logic   done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic   held = 1'b0;
    exp_t   held_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    flit_packetizer uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_cmd(in_cmd), .in_dest(in_dest),
        .in_has_line(in_has_line), .in_line(in_line),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_kind(out_kind), .out_seq(out_seq), .out_payload(out_payload)
    );

    task automatic check(input logic ok, input string tag, input logic [127:0] act,
                         input logic [127:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [511:0] make_line(input logic [7:0] base);
        logic [511:0] l;
        for (int i = 0; i < 64; i++) l[i*8 +: 8] = base + 8'(i);
        return l;
    endfunction

    // driver: called at a falling edge
    task automatic send(input logic [7:0] cmd, input logic [5:0] dest,
                        input logic has, input logic [511:0] line);
        exp_t e;
        in_valid = 1'b1; in_cmd = cmd; in_dest = dest;
        in_has_line = has; in_line = line;
        while (!in_ready) @(negedge clk);
        // accepted at the next rising edge
        e.seq = exp_seq;
        e.pay = 128'({dest, cmd});
        e.kind = has ? 2'b00 : 2'b11;
        expq.push_back(e);
        if (has) begin
            for (int k = 0; k < 4; k++) begin
                e.kind = (k == 3) ? 2'b10 : 2'b01;
                e.pay  = line[k*128 +: 128];
                expq.push_back(e);
            end
        end
        exp_seq = exp_seq + 8'd1;
        @(negedge clk);
        // R7: scramble every field while the packet is in flight
        in_valid = 1'b0; in_cmd = ~cmd; in_dest = ~dest;
        in_has_line = ~has; in_line = ~line;
    endtask

    // ready generator and monitor
    always @(negedge clk) begin
        if (mon_on) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = stall_mode ? lfsr[0] : 1'b1;
            if (held) begin
                check(out_valid && out_kind == held_val.kind && out_seq == held_val.seq
                      && out_payload == held_val.pay, "R8 hold", out_payload, held_val.pay);
            end
            if (out_valid) begin
                check(!in_ready, "R7 busy", 128'(in_ready), 128'(0));
            end
            held = out_valid && !out_ready;
            held_val = {out_kind, out_seq, out_payload};
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R9 unexpected flit", out_payload, 128'(0));
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(out_kind == e.kind, "R3 kind", 128'(out_kind), 128'(e.kind));
                    check(out_seq == e.seq, "R6 seq", 128'(out_seq), 128'(e.seq));
                    check(out_payload == e.pay,
                          (e.kind == 2'b00 || e.kind == 2'b11) ? "R5 head payload" : "R4 data chunk",
                          out_payload, e.pay);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(in_ready == 1'b1, "R1 in_ready", 128'(in_ready), 128'(1));
        check(out_valid == 1'b0, "R1 out_valid", 128'(out_valid), 128'(0));
        mon_on = 1'b1;
        // R2 bare command, first seq 0 (R1)
        send(8'h5A, 6'd17, 1'b0, make_line(8'h00));
        // R3/R4 line message
        send(8'h21, 6'd3, 1'b1, make_line(8'h40));
        // stall phase: R8
        stall_mode = 1'b1;
        send(8'h33, 6'd63, 1'b1, make_line(8'h80));
        send(8'h7F, 6'd0, 1'b0, make_line(8'h11));
        send(8'hC4, 6'd42, 1'b1, {16{32'hDEADBEEF}});
        // mix, long enough to wrap the sequence number (R6)
        for (int n = 0; n < 270; n++) begin
            stall_mode = (n % 3 == 0);
            send(8'(n * 7), 6'(n), (n % 5 == 0), make_line(8'(n)));
        end
        // R2: in_ready returns right after a single-flit packet
        stall_mode = 1'b0;
        for (int w = 0; w < 50 && expq.size() != 0; w++) @(negedge clk);
        @(negedge clk);
        check(expq.size() == 0, "R9 all flits delivered", 128'(expq.size()), 128'(0));
        check(in_ready == 1'b1 && out_valid == 1'b0, "R2 idle after drain",
              128'({in_ready, out_valid}), 128'(2'b10));
        mon_on = 1'b0;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule